// File: doc/BRIEF.md
# Octal Low-Side Gate Command and Protection

This block decides, every system clock cycle, whether each of eight low-side power channels has its gate enabled. Each channel has a serial request bit and a parallel request. It merges the two with a per-channel choice of OR or AND. The parallel request comes from four input pins. A polarity pin says whether those pins are active high or active low. The fourth pin can be routed to any set of channels through a routing mask.

The merged request then passes through the channel's protection stage. An over-temperature flag either blocks the channel only while it is present, or latches the channel off until its request rises again. A current-limit flag that stays up for a set number of cycles can latch the channel off in the same way. Each channel chooses its own reaction, and a channel can also be set never to be shut down by overload.

The result is registered and drives the gate enables and an identical state readback. Each channel's slow/fast slew choice is passed through to the output stage. Holding reset low puts the block to sleep, with every gate off.

Top module: `lsw_gate_ctrl`

## Requirements
- R1: With `pol_hi` = 1 a parallel pin at 1 is an active request. With `pol_hi` = 0 a pin at 0 is an active request.
- R2: For channel i, `and_sel[i]` = 0 gives the request `ser_ctl[i] | par`, and `and_sel[i]` = 1 gives `ser_ctl[i] & par`.
- R3: Channels 0, 1 and 2 take their parallel request from pins 0, 1 and 2. Each of them is also requested by pin 3 when its `map_sel` bit is 1. Channels 3 to 7 are requested only by pin 3, and only when their `map_sel` bit is 1. An unmapped channel 3 to 7 sees an inactive parallel request.
- R4: `gate_en` is registered. A change of request shows on `gate_en` after the next rising clock edge and not before it.
- R5: With `ovt_mode[i]` = 0, channel i is off in the cycle after `ot_flag[i]` is seen high. It comes back on one cycle after the flag clears, provided the request is still on.
- R6: With `ovt_mode[i]` = 1, a channel switched off by over-temperature stays off after the flag clears. It is released by a new 0-to-1 transition of its merged request.
- R7: With `ovl_mode[i]` = 1, `ilim_flag[i]` high on OVL_DLY consecutive edges while the channel is on turns the channel off after the last of those edges. It stays off until a new 0-to-1 transition of its request. A cycle with `ilim_flag[i]` low restarts the count.
- R8: With `ovl_mode[i]` = 0, a current-limit indication never turns the channel off.
- R9: `ot_flag[i]` seen while channel i is commanded off sets no latch. A later request switches the channel on, even in latching mode.
- R10: `state_rb` always equals `gate_en`, and `slew_sel[i]` equals `slew_cfg[i]`.
- R11: While `rst_n` is low every gate enable is 0. After reset is released, all latches and the overload count start cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset and sleep |
| pol_hi | input | 1 | Parallel pin polarity, 1 = active high |
| par_in | input | NPAR | Parallel request pins; the top pin is the routable one |
| ser_ctl | input | NCH | Serial request bit per channel |
| map_sel | input | NCH | Routing mask for the top parallel pin |
| and_sel | input | NCH | Merge select per channel, 0 = OR, 1 = AND |
| ovt_mode | input | NCH | Over-temperature reaction, 0 = restart, 1 = latch |
| ovl_mode | input | NCH | Overload reaction, 0 = limit only, 1 = latched shutdown |
| slew_cfg | input | NCH | Slew select per channel, 1 = slow |
| ot_flag | input | NCH | Over-temperature indication per channel |
| ilim_flag | input | NCH | Current-limit-active indication per channel |
| gate_en | output | NCH | Registered gate enable per channel |
| state_rb | output | NCH | Output state readback |
| slew_sel | output | NCH | Slew select to the output stage |

## Verification
The overload window property assumes that `ovl_mode[i]` holds steady while a current-limit episode on channel i is running. The bench changes modes only while `ilim_flag` is low, so this assumption holds.

The over-temperature property treats `ot_flag` as a clean synchronous level. The bench only changes flags one time unit after a rising edge, so each flag is stable when it is sampled.

The merge and routing logic is swept over both polarities, every pin pattern, and a range of masks, merge selects and serial words. The protection sequences run on channel 0, with all other channels idle.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

    typedef enum logic {
        COMB_OR  = 1'b0,
        COMB_AND = 1'b1
    } comb_op_e;

    function automatic logic merge_req(logic ser, logic par, comb_op_e op);
        return (op == COMB_AND) ? (ser & par) : (ser | par);
    endfunction

endpackage

// File: rtl/lsw_par_route.sv
module lsw_par_route #(
    parameter int NCH  = 8,
    parameter int NPAR = 4
) (
    input  logic            pol_hi,
    input  logic [NPAR-1:0] par_in,
    input  logic [NCH-1:0]  map_sel,
    output logic [NCH-1:0]  par_req
);
    localparam int SHARED = NPAR - 1;

    logic [NPAR-1:0] act;

    // Polarity: XNOR of pin with pol_hi yields active level
    assign act = pol_hi ? par_in : ~par_in;

    for (genvar i = 0; i < NCH; i++) begin : g_route
        if (i < SHARED) begin : g_own
            assign par_req[i] = act[i] | (map_sel[i] & act[SHARED]);
        end else begin : g_map
            assign par_req[i] = map_sel[i] & act[SHARED];
        end
    end
endmodule

// File: rtl/lsw_chan.sv
module lsw_chan
    import lsw_pkg::*;
#(
    parameter int OVL_DLY = 64
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ser,
    input  logic     par,
    input  comb_op_e op,
    input  logic     ovt_mode,
    input  logic     ovl_mode,
    input  logic     ot,
    input  logic     ilim,
    output logic     gate
);
    localparam int CW = $clog2(OVL_DLY + 1);

    typedef struct packed {
        logic          req;
        logic          ot_lat;
        logic          ovl_lat;
        logic          gate;
        logic [CW-1:0] cnt;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     req, rise, trip;

    always_comb begin
        st_d = st_q;
        req  = merge_req(ser, par, op);
        rise = req & ~st_q.req;
        trip = ovl_mode & ilim & st_q.gate & (st_q.cnt == CW'(OVL_DLY - 1));

        st_d.req     = req;
        // Temperature only counts while the channel is requested on
        st_d.ot_lat  = (st_q.ot_lat & ~rise) | (req & ot & ovt_mode);
        st_d.ovl_lat = (st_q.ovl_lat & ~rise) | trip;
        st_d.cnt     = (ovl_mode & ilim & st_q.gate & ~trip) ? st_q.cnt + CW'(1) : '0;
        st_d.gate    = req & ~ot & ~st_d.ot_lat & ~st_d.ovl_lat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate = st_q.gate;
endmodule

// File: rtl/lsw_gate_ctrl.sv
module lsw_gate_ctrl
    import lsw_pkg::*;
#(
    parameter int NCH     = 8,
    parameter int NPAR    = 4,
    parameter int OVL_DLY = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pol_hi,
    input  logic [NPAR-1:0] par_in,
    input  logic [NCH-1:0]  ser_ctl,
    input  logic [NCH-1:0]  map_sel,
    input  logic [NCH-1:0]  and_sel,
    input  logic [NCH-1:0]  ovt_mode,
    input  logic [NCH-1:0]  ovl_mode,
    input  logic [NCH-1:0]  slew_cfg,
    input  logic [NCH-1:0]  ot_flag,
    input  logic [NCH-1:0]  ilim_flag,
    output logic [NCH-1:0]  gate_en,
    output logic [NCH-1:0]  state_rb,
    output logic [NCH-1:0]  slew_sel
);
    logic [NCH-1:0] par_req;

    lsw_par_route #(.NCH(NCH), .NPAR(NPAR)) u_route (
        .pol_hi  (pol_hi),
        .par_in  (par_in),
        .map_sel (map_sel),
        .par_req (par_req)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        lsw_chan #(.OVL_DLY(OVL_DLY)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .ser      (ser_ctl[i]),
            .par      (par_req[i]),
            .op       (comb_op_e'(and_sel[i])),
            .ovt_mode (ovt_mode[i]),
            .ovl_mode (ovl_mode[i]),
            .ot       (ot_flag[i]),
            .ilim     (ilim_flag[i]),
            .gate     (gate_en[i])
        );
    end

    assign state_rb = gate_en;
    assign slew_sel = slew_cfg;
endmodule

// File: rtl/lsw_gate_ctrl_chk.sv
module lsw_gate_ctrl_chk #(
    parameter int NCH     = 8,
    parameter int OVL_DLY = 64
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] ser_ctl,
    input logic [NCH-1:0] and_sel,
    input logic [NCH-1:0] ovl_mode,
    input logic [NCH-1:0] ot_flag,
    input logic [NCH-1:0] ilim_flag,
    input logic [NCH-1:0] gate_en
);
    localparam int WW = $clog2(OVL_DLY + 2);

    assert_reset_off_R11: assert property (@(posedge clk)
        !rst_n |-> gate_en == '0);

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        logic [WW-1:0] win_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                win_q <= '0;
            end else if (gate_en[i] && ilim_flag[i] && ovl_mode[i]) begin
                if (win_q != WW'(OVL_DLY + 1)) win_q <= win_q + WW'(1);
            end else begin
                win_q <= '0;
            end
        end

        assert_ovl_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
            win_q <= WW'(OVL_DLY));

        assert_ot_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
            gate_en[i] |-> $past(!ot_flag[i]));

        assert_and_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (and_sel[i] && !ser_ctl[i]) |=> !gate_en[i]);
    end
endmodule

bind lsw_gate_ctrl lsw_gate_ctrl_chk #(.NCH(NCH), .OVL_DLY(OVL_DLY)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_ctl   (ser_ctl),
    .and_sel   (and_sel),
    .ovl_mode  (ovl_mode),
    .ot_flag   (ot_flag),
    .ilim_flag (ilim_flag),
    .gate_en   (gate_en)
);

// File: tb/lsw_gate_ctrl_bench.sv
module lsw_gate_ctrl_bench;
    localparam int NCH = 8;
    localparam int NPAR = 4;
    localparam int DLY = 5;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            pol_hi;
    logic [NPAR-1:0] par_in;
    logic [NCH-1:0]  ser_ctl, map_sel, and_sel, ovt_mode, ovl_mode;
    logic [NCH-1:0]  slew_cfg, ot_flag, ilim_flag;
    logic [NCH-1:0]  gate_en, state_rb, slew_sel;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lsw_gate_ctrl #(.NCH(NCH), .NPAR(NPAR), .OVL_DLY(DLY)) u_lsw_gate_ctrl (
        .clk(clk), .rst_n(rst_n), .pol_hi(pol_hi), .par_in(par_in),
        .ser_ctl(ser_ctl), .map_sel(map_sel), .and_sel(and_sel),
        .ovt_mode(ovt_mode), .ovl_mode(ovl_mode), .slew_cfg(slew_cfg),
        .ot_flag(ot_flag), .ilim_flag(ilim_flag), .gate_en(gate_en),
        .state_rb(state_rb), .slew_sel(slew_sel)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [NCH-1:0] act, logic [NCH-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [NCH-1:0] model(logic p, logic [NPAR-1:0] pins,
            logic [NCH-1:0] m, logic [NCH-1:0] a, logic [NCH-1:0] s);
        logic [NPAR-1:0] act;
        logic [NCH-1:0]  r;
        logic            pr;
        act = p ? pins : ~pins;
        for (int i = 0; i < NCH; i++) begin
            pr = (m[i] & act[NPAR-1]);
            if (i < NPAR - 1) pr = pr | act[i];
            r[i] = a[i] ? (s[i] & pr) : (s[i] | pr);
        end
        return r;
    endfunction

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [NCH-1:0] maps [4];
        logic [NCH-1:0] ands [3];
        logic [NCH-1:0] sers [3];
        logic [NCH-1:0] exp;
        maps[0] = 8'h08; maps[1] = 8'hFF; maps[2] = 8'h00; maps[3] = 8'hA5;
        ands[0] = 8'h00; ands[1] = 8'hFF; ands[2] = 8'h5A;
        sers[0] = 8'h00; sers[1] = 8'hFF; sers[2] = 8'h3C;

        rst_n = 1'b0; pol_hi = 1'b1; par_in = '1; ser_ctl = '1; map_sel = 8'h08;
        and_sel = '0; ovt_mode = '0; ovl_mode = '0; slew_cfg = 8'h96;
        ot_flag = '0; ilim_flag = '0;
        tick(); tick();
        chk("R11 gates off in reset", gate_en, 8'h00);
        chk("R10 slew passthrough", slew_sel, 8'h96);
        rst_n = 1'b1;

        // R1 R2 R3 sweep
        for (int p = 0; p < 2; p++)
            for (int pins = 0; pins < 16; pins++)
                for (int mi = 0; mi < 4; mi++)
                    for (int ai = 0; ai < 3; ai++)
                        for (int si = 0; si < 3; si++) begin
                            pol_hi = p[0]; par_in = pins[3:0]; map_sel = maps[mi];
                            and_sel = ands[ai]; ser_ctl = sers[si];
                            tick();
                            exp = model(p[0], pins[3:0], maps[mi], ands[ai], sers[si]);
                            chk("R1 R2 R3 merge", gate_en, exp);
                            chk("R10 readback", state_rb, gate_en);
                        end

        // Protection on channel 0: only serial requests
        pol_hi = 1'b1; par_in = '0; map_sel = '0; and_sel = '0; ser_ctl = '0;
        tick();
        // R4 registered
        ser_ctl = 8'h01; #1;
        chk("R4 no change before edge", gate_en, 8'h00);
        tick();
        chk("R4 on after edge", gate_en, 8'h01);

        // R5 autorestart
        ot_flag = 8'h01; tick();
        chk("R5 off on overtemp", gate_en, 8'h00);
        ot_flag = 8'h00; tick();
        chk("R5 restart after clear", gate_en, 8'h01);

        // R6 latching overtemp
        ovt_mode = 8'h01;
        ot_flag = 8'h01; tick();
        chk("R6 off on overtemp", gate_en, 8'h00);
        ot_flag = 8'h00; tick(); tick();
        chk("R6 stays off", gate_en, 8'h00);
        ser_ctl = 8'h00; tick();
        ser_ctl = 8'h01; tick();
        chk("R6 released by new rise", gate_en, 8'h01);

        // R9 ignored while off
        ser_ctl = 8'h00; ot_flag = 8'h01; tick(); tick();
        ot_flag = 8'h00; ser_ctl = 8'h01; tick();
        chk("R9 overtemp while off ignored", gate_en, 8'h01);
        ovt_mode = 8'h00;

        // R7 overload latch with restart of count
        ovl_mode = 8'h01;
        ilim_flag = 8'h01;
        for (int k = 0; k < DLY - 1; k++) tick();
        chk("R7 on before window", gate_en, 8'h01);
        ilim_flag = 8'h00; tick();
        ilim_flag = 8'h01;
        for (int k = 0; k < DLY - 1; k++) tick();
        chk("R7 count restarted", gate_en, 8'h01);
        tick();
        chk("R7 trips at window", gate_en, 8'h00);
        ilim_flag = 8'h00; tick();
        chk("R7 stays off", gate_en, 8'h00);
        ser_ctl = 8'h00; tick();
        ser_ctl = 8'h01; tick();
        chk("R7 released by new rise", gate_en, 8'h01);

        // R8 limit only
        ovl_mode = 8'h00;
        ilim_flag = 8'h01;
        for (int k = 0; k < 3 * DLY; k++) tick();
        chk("R8 no overload shutdown", gate_en, 8'h01);
        ilim_flag = 8'h00; tick();

        // R11 reset mid-run
        ser_ctl = 8'hFF; tick();
        chk("R11 all on before reset", gate_en, 8'hFF);
        rst_n = 1'b0; #1;
        chk("R11 reset forces off", gate_en, 8'h00);
        tick();
        chk("R11 held off in reset", gate_en, 8'h00);
        rst_n = 1'b1; tick();
        chk("R11 resumes after reset", gate_en, 8'hFF);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule